// File: doc/BRIEF.md
# Double-Buffered Pixel Stream Buffer

This block sits between a processor register bus and a display pipeline. Software writes 32-bit pixel words into a dual-clock memory of 2048 words, which is organised as two banks of 1024 words. The display side reads one bank while software fills the other. When the fill is complete, software raises a load command. The block then exchanges the roles of the two banks at the next frame boundary, so that no frame mixes old and new content.

The load command is taken from the rising edge of a control bit. It crosses from the bus clock to the pixel clock as a toggle. A flag stays set in the bus domain until the pixel domain confirms the swap, and software can poll this flag.

A second control bit selects a test mode. In test mode the pixel port outputs eight vertical colour bars in place of the stored pixels. The display side provides a pixel index and a frame-start pulse, and it receives 24-bit RGB one pixel-clock cycle later.

Top module: `pixel_pingpong_buf`

## Requirements
- R1: After reset, bank 0 is displayed, bank 1 is writable, no swap is pending, and both control bits are 0.
- R2: The control register is at byte offset 0x0. Bit 0 is test mode and bit 1 is load. A read of 0x0 returns these two bits in bits 1:0 and zeros elsewhere. Writing 0 clears both bits.
- R3: A write to byte offset 0x10 + 4*i, for i from 0 to 1023, stores the word at index i of the writable bank. What the display shows does not change.
- R4: A 0-to-1 transition of load bit 1 issues exactly one bank swap. Keeping the bit at 1 issues no further swap.
- R5: An issued swap reaches the display only at a cycle in which frame_start is high. Until then the previously displayed bank is still read.
- R6: A read of byte offset 0x4 returns the writable bank in bit 0 and the swap-pending flag in bit 1. Pending is set from the cycle after the swap is issued. It clears once the pixel domain has applied the swap and that fact has been synchronised back to the bus clock.
- R7: A load rising edge that arrives while a swap is pending is ignored.
- R8: pix_rgb is bits 23:0 of the addressed word of the displayed bank, with red in 23:16, green in 15:8 and blue in 7:0. It appears one pixel-clock cycle after pix_addr.
- R9: In test mode, pix_rgb ignores the memory. The bar number is pix_addr[9:7]. Red is 0xFF when bar bit 2 is set, green is 0xFF when bar bit 1 is set, blue is 0xFF when bar bit 0 is set, and each channel is 0x00 otherwise.
- R10: Writes to any offset other than 0x0 and the word-aligned range 0x10 to 0x100C change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 16 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, available in the same cycle |
| clk_pix | input | 1 | Screen pixel clock |
| rst_pix | input | 1 | Synchronous active-high reset, pixel domain |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| pix_addr | input | 10 | Pixel index within the displayed bank |
| pix_rgb | output | 24 | Pixel colour, one cycle after pix_addr |

## Verification
The assertions check three rules on every cycle:
- the writable bank holds while load stays high, and while a swap is pending;
- the displayed bank changes only in a frame-start cycle;
- in test mode every colour channel is exactly 0x00 or 0xFF.

Several behaviours need the bench's scenarios instead, because they involve data round trips and crossings between the two clocks:
- the data round trip through the memory into the correct bank;
- the one-cycle pixel latency;
- the pending flag rising and then clearing after the two clock-domain crossings;
- a swap held back until frame_start;
- address aliasing from misaligned or out-of-range writes.

// File: rtl/pxbuf_pkg.sv
package pxbuf_pkg;

    localparam int WORD_W      = 32;
    localparam int CH_W        = 8;
    localparam int RGB_W       = 3 * CH_W;
    localparam int CTRL_W      = 2;
    localparam logic [15:0] CTRL_OFS = 16'h0000;
    localparam logic [15:0] STAT_OFS = 16'h0004;
    localparam logic [15:0] PIX_BASE = 16'h0010;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] green;
        logic [CH_W-1:0] blue;
    } rgb_t;

    typedef struct packed {
        logic load;
        logic test;
    } ctrl_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_STAT,
        ACC_PIX
    } access_e;

    function automatic rgb_t bar_colour(input logic [2:0] bar);
        rgb_t c;
        c.red   = bar[2] ? '1 : '0;
        c.green = bar[1] ? '1 : '0;
        c.blue  = bar[0] ? '1 : '0;
        return c;
    endfunction

endpackage

// File: rtl/pxbuf_sync.sv
module pxbuf_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/pxbuf_dpram.sv
module pxbuf_dpram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/pxbuf_bus_regs.sv
module pxbuf_bus_regs
    import pxbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              ack_tog,
    output logic              req_tog,
    output logic              test_mode,
    output logic              ram_we,
    output logic [IDX_W:0]    ram_waddr,
    output logic [WORD_W-1:0] ram_wdata
);
    localparam logic [ADDR_W-1:0] PIX_LO = ADDR_W'(PIX_BASE);
    localparam logic [ADDR_W-1:0] PIX_HI = ADDR_W'(PIX_BASE + ((1 << IDX_W) - 1) * 4);

    ctrl_t            ctrl_q;
    logic             load_prev;
    logic             wr_bank;
    logic             pending;
    logic             ld_edge;
    logic             issue;
    access_e          acc;
    logic [ADDR_W-1:0] offs;

    always_comb begin
        acc = ACC_NONE;
        if (addr == ADDR_W'(CTRL_OFS))      acc = ACC_CTRL;
        else if (addr == ADDR_W'(STAT_OFS)) acc = ACC_STAT;
        else if (addr[1:0] == 2'b00 && addr >= PIX_LO && addr <= PIX_HI) acc = ACC_PIX;
    end

    assign offs    = addr - PIX_LO;
    assign pending = req_tog ^ ack_tog;
    assign ld_edge = ctrl_q.load & ~load_prev;
    assign issue   = ld_edge & ~pending;

    assign ram_we    = we && (acc == ACC_PIX);
    assign ram_waddr = {wr_bank, offs[IDX_W+1:2]};
    assign ram_wdata = wdata;
    assign test_mode = ctrl_q.test;

    always_comb begin
        rdata = '0;
        case (acc)
            ACC_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
            ACC_STAT: rdata[1:0]        = {pending, wr_bank};
            default:  rdata             = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            load_prev <= 1'b0;
            wr_bank   <= 1'b1;
            req_tog   <= 1'b0;
        end else begin
            if (we && acc == ACC_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            load_prev <= ctrl_q.load;
            if (issue) begin
                wr_bank <= ~wr_bank;
                req_tog <= ~req_tog;
            end
        end
    end

    AST_HELD_LOAD_ONE_SWAP: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.load && load_prev) |=> $stable(wr_bank)); // R4

    AST_PENDING_BLOCKS_SWAP: assert property (@(posedge clk) disable iff (rst)
        pending |=> $stable(wr_bank)); // R7

endmodule

// File: rtl/pxbuf_pix_read.sv
module pxbuf_pix_read
    import pxbuf_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              req_tog,
    input  logic              test_mode,
    input  logic [IDX_W-1:0]  pix_addr,
    input  logic [WORD_W-1:0] ram_q,
    output logic [IDX_W:0]    ram_raddr,
    output logic              app_tog,
    output logic [RGB_W-1:0]  rgb
);
    logic disp_bank;
    logic test_q;
    rgb_t bar_q;
    rgb_t mem_px;

    assign ram_raddr = {disp_bank, pix_addr};
    assign mem_px    = rgb_t'(ram_q[RGB_W-1:0]);
    assign rgb       = test_q ? bar_q : mem_px;

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_bank <= 1'b0;
            app_tog   <= 1'b0;
            test_q    <= 1'b0;
            bar_q     <= '0;
        end else begin
            if (frame_start && (req_tog != app_tog)) begin
                disp_bank <= ~disp_bank;
                app_tog   <= req_tog;
            end
            test_q <= test_mode;
            bar_q  <= bar_colour(pix_addr[IDX_W-1 -: 3]);
        end
    end

    AST_SWAP_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(disp_bank)); // R5

    AST_BAR_FULL_LEVELS: assert property (@(posedge clk) disable iff (rst)
        test_q |-> ((bar_q.red == 8'h00 || bar_q.red == 8'hFF) &&
                    (rgb[15:8] == 8'h00 || rgb[15:8] == 8'hFF) &&
                    (rgb[7:0] == 8'h00 || rgb[7:0] == 8'hFF))); // R9

endmodule

// File: rtl/pixel_pingpong_buf.sv
module pixel_pingpong_buf
    import pxbuf_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int IDX_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_bus,
    input  logic              rst_bus,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              clk_pix,
    input  logic              rst_pix,
    input  logic              frame_start,
    input  logic [IDX_W-1:0]  pix_addr,
    output logic [RGB_W-1:0]  pix_rgb
);
    logic              req_tog;
    logic              test_bus;
    logic              ack_bus;
    logic              app_tog;
    logic [1:0]        to_pix_q;
    logic              ram_we;
    logic [IDX_W:0]    ram_waddr;
    logic [WORD_W-1:0] ram_wdata;
    logic [IDX_W:0]    ram_raddr;
    logic [WORD_W-1:0] ram_q;

    pxbuf_bus_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk_bus), .rst(rst_bus), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .ack_tog(ack_bus),
        .req_tog(req_tog), .test_mode(test_bus), .ram_we(ram_we),
        .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
    );

    pxbuf_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_to_pix (
        .clk(clk_pix), .rst(rst_pix), .d({test_bus, req_tog}), .q(to_pix_q)
    );

    pxbuf_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_to_bus (
        .clk(clk_bus), .rst(rst_bus), .d(app_tog), .q(ack_bus)
    );

    pxbuf_dpram #(.DATA_W(WORD_W), .ADDR_W(IDX_W + 1)) u_ram (
        .wclk(clk_bus), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .rclk(clk_pix), .raddr(ram_raddr), .rdata(ram_q)
    );

    pxbuf_pix_read #(.IDX_W(IDX_W)) u_read (
        .clk(clk_pix), .rst(rst_pix), .frame_start(frame_start),
        .req_tog(to_pix_q[0]), .test_mode(to_pix_q[1]), .pix_addr(pix_addr),
        .ram_q(ram_q), .ram_raddr(ram_raddr), .app_tog(app_tog), .rgb(pix_rgb)
    );

endmodule

// File: tb/pixel_pingpong_buf_bench.sv
module pixel_pingpong_buf_bench;
    import pxbuf_pkg::*;

    logic        clk_bus = 1'b0;
    logic        clk_pix = 1'b0;
    logic        rst_bus, rst_pix;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        frame_start;
    logic [9:0]  pix_addr;
    logic [23:0] pix_rgb;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] model [2][1024];
    int  exp_disp = 0;
    int  exp_wr   = 1;
    bit  exp_test = 1'b0;
    bit  done     = 1'b0;

    always #2   clk_bus = ~clk_bus;
    always #3.5 clk_pix = ~clk_pix;

    pixel_pingpong_buf u_pixel_pingpong_buf (
        .clk_bus(clk_bus), .rst_bus(rst_bus), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_pix(clk_pix),
        .rst_pix(rst_pix), .frame_start(frame_start), .pix_addr(pix_addr),
        .pix_rgb(pix_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_pix(input int idx);
        rgb_t c;
        if (exp_test) begin
            c.red   = idx[9] ? 8'hFF : 8'h00;
            c.green = idx[8] ? 8'hFF : 8'h00;
            c.blue  = idx[7] ? 8'hFF : 8'h00;
            return c;
        end
        return model[exp_disp][idx][23:0];
    endfunction

    task automatic bw(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk_bus);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk_bus);
        bus_we = 1'b0;
    endtask

    task automatic br(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk_bus);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic put(input int idx, input logic [31:0] d);
        bw(16'h0010 + 16'(idx * 4), d);
        model[exp_wr][idx] = d;
    endtask

    task automatic chk_pix(input string req, input int idx);
        @(negedge clk_pix);
        pix_addr = 10'(idx);
        @(negedge clk_pix);
        check(req, {8'h0, pix_rgb}, {8'h0, exp_pix(idx)});
    endtask

    task automatic frame();
        @(negedge clk_pix); frame_start = 1'b1;
        @(negedge clk_pix); frame_start = 1'b0;
    endtask

    task automatic chk_status(input string req, input bit pend);
        logic [31:0] d;
        br(16'h0004, d);
        check(req, d, {30'b0, pend, exp_wr[0]});
    endtask

    task automatic fill_all();
        for (int i = 0; i < 1024; i++) put(i, $urandom);
    endtask

    task automatic load_and_show();
        bw(16'h0000, {30'b0, 1'b1, exp_test});
        exp_wr ^= 1;
        bw(16'h0000, {31'b0, exp_test});
        repeat (4) @(negedge clk_pix);
        frame();
        exp_disp ^= 1;
        repeat (8) @(negedge clk_bus);
    endtask

    initial begin
        repeat (200000) @(posedge clk_bus);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h1234_5678));
        rst_bus = 1'b1; rst_pix = 1'b1;
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        frame_start = 1'b0; pix_addr = '0;
        repeat (5) @(negedge clk_pix);
        rst_bus = 1'b0; rst_pix = 1'b0;

        // R1 / R2 reset state
        br(16'h0000, d); check("R1 ctrl after reset", d, 32'h0);
        chk_status("R1 bank1 writable, none pending", 1'b0);

        // R3 fill bank 1, then R4/R6 swap issue
        fill_all();
        bw(16'h0000, 32'h2);
        exp_wr ^= 1;
        chk_status("R6 pending after load edge", 1'b1);
        bw(16'h0000, 32'h0);
        br(16'h0000, d); check("R2 write 0 clears ctrl", d, 32'h0);
        repeat (4) @(negedge clk_pix);
        frame();
        exp_disp ^= 1;
        repeat (8) @(negedge clk_bus);
        chk_status("R6 pending clears after frame", 1'b0);

        // R8 pixel contents, corners and random
        chk_pix("R8 index 0", 0);
        chk_pix("R8 index 1023", 1023);
        for (int k = 0; k < 24; k++) chk_pix("R8 random index", int'($urandom_range(0, 1023)));

        // R3 filling the hidden bank leaves the display alone
        fill_all();
        for (int k = 0; k < 12; k++) chk_pix("R3 display untouched", int'($urandom_range(0, 1023)));

        // R4 held load gives one swap, R7 edge while pending ignored, R5 wait for frame
        bw(16'h0000, 32'h2);
        exp_wr ^= 1;
        bw(16'h0000, 32'h2);
        repeat (6) @(negedge clk_bus);
        chk_status("R4 held load swaps once", 1'b1);
        bw(16'h0000, 32'h0);
        bw(16'h0000, 32'h2);
        repeat (3) @(negedge clk_bus);
        chk_status("R7 load while pending ignored", 1'b1);
        bw(16'h0000, 32'h0);
        repeat (6) @(negedge clk_pix);
        chk_pix("R5 old bank before frame", 5);
        chk_pix("R5 old bank before frame", 900);
        frame();
        exp_disp ^= 1;
        repeat (8) @(negedge clk_bus);
        chk_status("R5 swap applied at frame", 1'b0);
        chk_pix("R5 new bank after frame", 5);
        chk_pix("R5 new bank after frame", 900);

        // R9 test mode bars
        bw(16'h0000, 32'h1);
        exp_test = 1'b1;
        br(16'h0000, d); check("R2 ctrl reads test bit", d, 32'h1);
        repeat (4) @(negedge clk_pix);
        for (int b = 0; b < 8; b++) chk_pix("R9 colour bar", b * 128 + int'($urandom_range(0, 127)));
        bw(16'h0000, 32'h0);
        exp_test = 1'b0;
        repeat (4) @(negedge clk_pix);
        chk_pix("R9 back to memory", 300);

        // R10 stray writes
        bw(16'h0008, 32'hFFFF_FFFF);
        bw(16'h0012, 32'hDEAD_BEEF);
        bw(16'h1010, 32'hDEAD_BEEF);
        bw(16'h100E, 32'hDEAD_BEEF);
        bw(16'hFFFC, 32'hDEAD_BEEF);
        bw(16'h000C, 32'hDEAD_BEEF);
        br(16'h0000, d); check("R10 ctrl untouched", d, 32'h0);
        chk_status("R10 status untouched", 1'b0);
        load_and_show();
        chk_pix("R10 index 0 intact", 0);
        chk_pix("R10 index 1 intact", 1);
        chk_pix("R10 index 1023 intact", 1023);

        // random rounds
        for (int r = 0; r < 4; r++) begin
            int idx [6];
            for (int k = 0; k < 6; k++) begin
                idx[k] = int'($urandom_range(0, 1023));
                put(idx[k], $urandom);
            end
            load_and_show();
            for (int k = 0; k < 6; k++) chk_pix("R3 random round", idx[k]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule